// File: doc/BRIEF.md
# Serial-Priority Interrupt Acknowledge Chain

This block joins a parameterised number of interrupt-capable device stages into one serial priority chain. Each stage catches a rising edge on its own device request input and holds it as a pending request. All stages share one active-low request line toward the processor. The line goes low while any stage has a request pending and stays high when none does.

The processor answers with a single acknowledge input that enters stage 0. Within the same cycle it ripples through the chain: a stage with no pending request hands it on to the next stage, and the first pending stage keeps it. That stage puts its own 8-bit vector on the shared vector bus and clears its pending request at the next clock edge. Position in the chain fixes the priority, with stage 0 the highest. Requests that lose stay pending and keep the line low until later acknowledges serve them in index order.

Top module: `intr_priority_chain`

## Requirements
- R1: After reset `irq_n` is 1, `vec_bus` is 0, `vec_valid` is 0 and `ack_tail` is 0.
- R2: A 0-to-1 change of `dev_req[i]` between two consecutive clock edges sets stage i pending at the second edge. `irq_n` goes low in the cycle after that edge.
- R3: `irq_n` is 0 exactly when at least one stage is pending, and 1 otherwise.
- R4: When `int_ack` is 1 and no stage is pending, the acknowledge passes through every stage and `ack_tail` is 1 in the same cycle. `ack_tail` is 0 whenever `int_ack` is 0.
- R5: When `int_ack` is 1, the lowest-indexed pending stage i wins in the same cycle. `vec_valid` is 1, `vec_bus` equals `VEC_BASE + i*VEC_STEP` (8 bits, modulo 256), and `ack_tail` is 0.
- R6: The winning stage's pending request clears at the clock edge that ends the winning cycle. Other pending stages are unchanged and win on later acknowledges in ascending index order.
- R7: In any cycle with no winner, `vec_valid` is 0 and `vec_bus` is 0.
- R8: If stage i sees a rising request edge in the same cycle that it wins, it is still pending afterwards.
- R9: A request held high causes one pending event only. After that request is served, it does not set the stage pending again until the input falls and rises once more.

Top module parameters: `N_STAGES` (default 4), `VEC_W` (default 8), `VEC_BASE` (default 8'h40), `VEC_STEP` (default 8'h04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | N_STAGES | Device request inputs; a rising edge records a request; bit 0 has the highest priority |
| int_ack | input | 1 | Interrupt acknowledge from the processor, fed into stage 0 |
| irq_n | output | 1 | Shared active-low interrupt request line |
| vec_bus | output | VEC_W | Vector of the winning stage; 0 when there is no winner |
| vec_valid | output | 1 | A stage holds the acknowledge this cycle |
| ack_tail | output | 1 | Acknowledge leaving the last stage unclaimed |

## Verification
Two things can happen to a stage in one cycle: it can win the acknowledge, which clears its request, and it can see a new rising request edge, which sets it. The bench lowers a stage's request input after the stage is pending. It then raises the input again in the very cycle the acknowledge arrives, so that the clear and the set land on the same edge. The bench judges the result by the line staying low and by a second acknowledge returning that stage's vector. A behavioural model compares every output on every cycle, and it covers the plain case where several stages are pending together and are drained one per acknowledge.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;

    // Registered state of one chain stage
    typedef struct packed {
        logic req_seen;   // device request level seen at the previous edge
        logic pend;       // request recorded and not yet served
    } stage_state_t;

    localparam stage_state_t STAGE_RESET = '{req_seen: 1'b0, pend: 1'b0};

endpackage

// File: rtl/intr_chain_stage.sv
module intr_chain_stage
    import intr_chain_pkg::*;
#(
    parameter int          VEC_W     = 8,
    parameter logic [VEC_W-1:0] STAGE_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_req,
    input  logic             pri_in,
    output logic             pri_out,
    output logic             pend,
    output logic             grant,
    output logic [VEC_W-1:0] vec_drv
);

    stage_state_t st_q, st_d;
    logic         rise;

    // Next-state and chain gating
    always_comb begin
        st_d          = st_q;
        rise          = dev_req & ~st_q.req_seen;
        grant         = pri_in & st_q.pend;
        pri_out       = pri_in & ~st_q.pend;
        st_d.req_seen = dev_req;
        if (rise) begin
            st_d.pend = 1'b1;          // a new edge outranks the clear
        end else if (grant) begin
            st_d.pend = 1'b0;
        end
        vec_drv = grant ? STAGE_VEC : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STAGE_RESET;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R6: service clears the request unless a fresh edge arrives
    a_r6_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !rise) |=> !pend);

    // R8: a fresh edge leaves the stage pending even when it wins
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && grant) |=> pend);

    // R9: pending only ever sets after a low-to-high input change
    a_r9_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ($past(dev_req) && !$past(st_q.req_seen)));

endmodule

// File: rtl/intr_req_line.sv
module intr_req_line #(
    parameter int N_STAGES = 4
) (
    input  logic [N_STAGES-1:0] pull_low,
    output logic                line_n
);

    // Each stage either releases (1) or pulls down (0); the line is their AND
    logic [N_STAGES:0] acc;

    assign acc[0] = 1'b1;

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_tap
            assign acc[g+1] = acc[g] & ~pull_low[g];
        end
    endgenerate

    assign line_n = acc[N_STAGES];

endmodule

// File: rtl/intr_vec_merge.sv
module intr_vec_merge #(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8
) (
    input  logic [N_STAGES-1:0][VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0]               vec_out
);

    // OR-combined bus: idle stages drive zero
    logic [N_STAGES:0][VEC_W-1:0] acc;

    assign acc[0] = '0;

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_or
            assign acc[g+1] = acc[g] | vec_in[g];
        end
    endgenerate

    assign vec_out = acc[N_STAGES];

endmodule

// File: rtl/intr_priority_chain.sv
module intr_priority_chain #(
    parameter int               N_STAGES = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
    parameter logic [VEC_W-1:0] VEC_STEP = 8'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] dev_req,
    input  logic                int_ack,
    output logic                irq_n,
    output logic [VEC_W-1:0]    vec_bus,
    output logic                vec_valid,
    output logic                ack_tail
);

    localparam int LINKS = N_STAGES + 1;

    logic [LINKS-1:0]                ack_link;
    logic [N_STAGES-1:0]             pend_v;
    logic [N_STAGES-1:0]             grant_v;
    logic [N_STAGES-1:0][VEC_W-1:0]  vec_v;

    assign ack_link[0] = int_ack;

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
            localparam logic [VEC_W-1:0] THIS_VEC = VEC_W'(VEC_BASE + VEC_STEP * g);
            intr_chain_stage #(
                .VEC_W     (VEC_W),
                .STAGE_VEC (THIS_VEC)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .dev_req (dev_req[g]),
                .pri_in  (ack_link[g]),
                .pri_out (ack_link[g+1]),
                .pend    (pend_v[g]),
                .grant   (grant_v[g]),
                .vec_drv (vec_v[g])
            );
        end
    endgenerate

    intr_req_line #(.N_STAGES(N_STAGES)) u_line (
        .pull_low (pend_v),
        .line_n   (irq_n)
    );

    intr_vec_merge #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_merge (
        .vec_in  (vec_v),
        .vec_out (vec_bus)
    );

    assign vec_valid = |grant_v;
    assign ack_tail  = ack_link[N_STAGES];

    // R5: at most one stage holds the acknowledge
    a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_v));

    // R3: the wired line reflects the stage requests
    a_r3_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n == (pend_v == '0)));

    // R4: without an acknowledge nothing wins and nothing leaves the chain
    a_r4_no_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |-> (!vec_valid && !ack_tail));

    // R7: the bus is quiet when nobody wins
    a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_bus == '0));

    // R5: a winner and an escaping acknowledge exclude each other
    a_r5_win_blocks_tail: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (!ack_tail && !irq_n));

endmodule

// File: tb/sim_intr_priority_chain.sv
`timescale 1ns/1ps
module sim_intr_priority_chain;

    localparam int       N    = 4;
    localparam bit [7:0] BASE = 8'h40;
    localparam bit [7:0] STEP = 8'h04;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic         int_ack = 1'b0;
    logic         irq_n;
    logic [7:0]   vec_bus;
    logic         vec_valid;
    logic         ack_tail;

    always #2.5 clk = ~clk;

    intr_priority_chain #(.N_STAGES(N), .VEC_W(8), .VEC_BASE(BASE), .VEC_STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .int_ack(int_ack),
        .irq_n(irq_n), .vec_bus(vec_bus), .vec_valid(vec_valid), .ack_tail(ack_tail)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    m_pend [N];
    bit    m_prev [N];
    string tag = "R1";

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int winner();
        for (int i = 0; i < N; i++) if (m_pend[i]) return i;
        return -1;
    endfunction

    // One cycle: compare at the falling edge, then advance the model at the rising edge
    task automatic cyc();
        int  w;
        bit  e_irq, e_vld, e_tail;
        bit [7:0] e_vec;
        @(negedge clk);
        w      = int_ack ? winner() : -1;
        e_irq  = (winner() < 0);
        e_vld  = (w >= 0);
        e_vec  = e_vld ? 8'(BASE + STEP * w) : 8'h00;
        e_tail = int_ack && (winner() < 0);
        chk(irq_n == e_irq,       "irq_n",     irq_n,     e_irq);
        chk(vec_valid == e_vld,   "vec_valid", vec_valid, e_vld);
        chk(vec_bus == e_vec,     "vec_bus",   vec_bus,   e_vec);
        chk(ack_tail == e_tail,   "ack_tail",  ack_tail,  e_tail);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            bit rise = dev_req[i] && !m_prev[i];
            if (rise)          m_pend[i] = 1'b1;
            else if (i == w)   m_pend[i] = 1'b0;
            m_prev[i] = dev_req[i];
        end
        #1;
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) cyc();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
        // R1: reset values
        tag = "R1";
        @(negedge clk);
        chk(irq_n == 1'b1 && vec_bus == 8'h00 && vec_valid == 1'b0 && ack_tail == 1'b0,
            "reset outputs", {irq_n, vec_valid, ack_tail}, 3'b100);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cycles(2);

        // R4: acknowledge with nothing pending runs off the end
        tag = "R4";
        int_ack = 1'b1; cyc(); int_ack = 1'b0; cycles(1);

        // R2 and R3: single request on stage 2
        tag = "R2";
        dev_req[2] = 1'b1; cycles(2);
        tag = "R3"; cycles(1);
        // R5 and R6: serve it
        tag = "R5"; int_ack = 1'b1; cyc(); int_ack = 1'b0;
        tag = "R6"; cycles(2);
        // R9: held level does not re-request
        tag = "R9"; cycles(3);
        int_ack = 1'b1; cyc(); int_ack = 1'b0; cycles(1);
        dev_req = '0; cycles(1);

        // R5 and R6: all stages at once, drained in order by spaced pulses
        tag = "R5";
        dev_req = '1; cycles(2);
        for (int k = 0; k < N; k++) begin
            tag = "R6";
            int_ack = 1'b1; cyc(); int_ack = 1'b0; cycles(1);
        end
        tag = "R4"; int_ack = 1'b1; cyc(); int_ack = 1'b0;
        dev_req = '0; cycles(1);

        // R6: stages 1 and 3, acknowledge held for three cycles
        tag = "R6";
        dev_req[1] = 1'b1; dev_req[3] = 1'b1; cycles(2);
        int_ack = 1'b1; cycles(3); int_ack = 1'b0;
        dev_req = '0; cycles(1);

        // R7: pending but no acknowledge keeps the bus quiet
        tag = "R7";
        dev_req[0] = 1'b1; cycles(3);
        int_ack = 1'b1; cyc(); int_ack = 1'b0;
        dev_req = '0; cycles(1);

        // R8: new edge on stage 1 in the cycle stage 1 wins
        tag = "R8";
        dev_req[1] = 1'b1; cyc(); dev_req[1] = 1'b0; cycles(2);
        dev_req[1] = 1'b1; int_ack = 1'b1; cyc(); int_ack = 1'b0;
        cycles(2);
        int_ack = 1'b1; cyc(); int_ack = 1'b0;
        dev_req = '0; cycles(2);

        // R2: short pulses on stages 3 and 0 in different cycles
        tag = "R2";
        dev_req[3] = 1'b1; cyc(); dev_req[3] = 1'b0;
        dev_req[0] = 1'b1; cyc(); dev_req[0] = 1'b0; cycles(1);
        tag = "R5";
        int_ack = 1'b1; cyc(); cyc(); int_ack = 1'b0; cycles(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule